// File: doc/BRIEF.md
# Byte-Lane Burst Cache Memory

This block is a clocked memory of 18-bit words split into two independently writable 9-bit lanes, each lane being 8 data bits plus 1 parity bit. Every cycle is started or continued at the rising clock edge by a small decoder. It looks at chip select and two active-low address strobes. One strobe comes from a processor and one from a cache controller. The processor strobe only counts while the chip is selected, and it wins when both strobes are low. A controller-strobe write completes in the cycle it starts. A processor-strobe cycle always opens as an address phase. The write, if any, follows at the next edge.

Once an address is loaded, an advance input steps a 2-bit wrapping counter through the low two address bits. The step order is either interleaved, where the start offset is XORed with the count, or linear, where the count is added to the start offset modulo 4. A parameter picks the order. Read data is registered. An asynchronous output enable, the selected state and the per-lane write enables combine into one enable flag per lane. These flags replace a tri-state bus. A disabled lane reads as zero on the output bus.

Top module: `bsram_lane_ctrl`

## Requirements
- R1: After reset both lane enable flags are 0 and the read bus is all zero.
- R2: Bus layout: lane 0 is bits [8:0] (data [7:0], parity bit 8) and is written by lane_we_ni[0]. Lane 1 is bits [17:9] (data [16:9], parity bit 17) and is written by lane_we_ni[1]. A write to one lane leaves the other lane of that word unchanged.
- R3: At an edge where cs_ni=0 and cpu_stb_ni=0, both lane write enables are ignored and no word is written. A write follows at the next edge if a lane write enable is low at that edge.
- R4: At an edge where cs_ni=0, ctl_stb_ni=0 and cpu_stb_ni=1, each lane whose write enable is low is written with wdata_i at addr_i in that same edge.
- R5: At an edge where both strobes are high, each lane whose write enable is low is written at the current burst address, whatever cs_ni is.
- R6: With adv_ni=0 and both strobes high, the low two address bits step from the loaded offset s as s^k with PARAM_LINEAR=0, or as s+k mod 4 with PARAM_LINEAR=1, for k=1,2,3 and then wrapping to 0. The upper bits are held.
- R7: adv_ni is ignored on a load or deselect edge. With adv_ni=1 the burst address is held.
- R8: Read data for the address used at an edge appears on rdata_o after that edge. A lane is driven only while its flag is 1. A lane whose flag is 0 reads as zero.
- R9: While oe_ni=1 both lane flags are 0, without waiting for a clock edge.
- R10: After an edge where a lane's write enable is low, that lane's flag is 0 for the cycle, including on a processor-strobe edge, regardless of oe_ni.
- R11: An edge with cs_ni=1 and ctl_stb_ni=0 deselects the block: both flags are 0 until the next load. With cs_ni=1 the processor strobe is ignored, and the edge acts as a burst cycle.
- R12: When both strobes are low with cs_ni=0, the processor strobe wins: the address loads and the write enables are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Word address loaded by a strobe |
| cs_ni | input | 1 | Chip select, active low, sampled |
| cpu_stb_ni | input | 1 | Processor address strobe, active low |
| ctl_stb_ni | input | 1 | Controller address strobe, active low |
| adv_ni | input | 1 | Burst advance, active low |
| lane_we_ni | input | 2 | Per-lane write enables, active low |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| wdata_i | input | 18 | Write data, captured at the write edge |
| rdata_o | output | 18 | Read data, disabled lanes zero |
| lane_oe_o | output | 2 | Per-lane output drive flags |

## Verification
A partial write and a read can fall in the same cycle. A controller-strobe edge with one lane write enable low and oe_ni low writes one lane while the other lane shows its old word. The scoreboard checks each lane's flag and value separately: the written lane must be off and the other must carry its previous contents. The same coincidence is provoked inside a burst, where an advance and a one-lane write share an edge, and the next read-back must show the merged word at the stepped address.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
  localparam int unsigned LANE_W = 9;
  localparam int unsigned LANES  = 2;
  localparam int unsigned WORD_W = LANE_W * LANES;

  typedef logic [1:0] boff_t;

  function automatic boff_t burst_low(input boff_t start, input boff_t cnt, input bit linear);
    return linear ? boff_t'(start + cnt) : (start ^ cnt);
  endfunction
endpackage

// File: rtl/bsram_addr_gen.sv
module bsram_addr_gen
  import bsram_pkg::*;
#(
  parameter int unsigned ADDR_W       = 6,
  parameter bit          PARAM_LINEAR = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] eff_addr_o
);
  localparam int unsigned HI_W = ADDR_W - 2;

  logic [HI_W-1:0] base_q, base_d;
  boff_t           start_q, start_d;
  boff_t           cnt_q, cnt_d;

  always_comb begin
    base_d  = base_q;
    start_d = start_q;
    cnt_d   = cnt_q;
    if (load_i) begin
      base_d  = addr_i[ADDR_W-1:2];
      start_d = addr_i[1:0];
      cnt_d   = '0;
    end else if (step_i) begin
      cnt_d = cnt_q + 2'd1;
    end
  end

  assign eff_addr_o = {base_d, burst_low(start_d, cnt_d, PARAM_LINEAR)};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      start_q <= '0;
      cnt_q   <= '0;
    end else begin
      base_q  <= base_d;
      start_q <= start_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/bsram_cycle_ctrl.sv
module bsram_cycle_ctrl
  import bsram_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             cpu_stb_ni,
  input  logic             ctl_stb_ni,
  input  logic             adv_ni,
  input  logic [LANES-1:0] lane_we_ni,
  output logic             load_o,
  output logic             step_o,
  output logic [LANES-1:0] lane_wr_o,
  output logic             sel_o,
  output logic [LANES-1:0] we_seen_o
);
  logic cpu_load, ctl_load, desel;
  logic sel_q;
  logic [LANES-1:0] we_seen_q;

  assign cpu_load = !cs_ni && !cpu_stb_ni;
  assign ctl_load = !cs_ni && !ctl_stb_ni && cpu_stb_ni;
  assign desel    = cs_ni && !ctl_stb_ni;

  assign load_o = cpu_load || ctl_load;
  assign step_o = !load_o && !desel && !adv_ni;

  // processor-strobe edge is an address phase: write enables have no effect
  for (genvar l = 0; l < LANES; l++) begin : g_wr
    assign lane_wr_o[l] = !lane_we_ni[l] && !cpu_load && !desel;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q     <= 1'b0;
      we_seen_q <= '0;
    end else begin
      if (load_o)     sel_q <= 1'b1;
      else if (desel) sel_q <= 1'b0;
      we_seen_q <= ~lane_we_ni;
    end
  end

  assign sel_o     = sel_q;
  assign we_seen_o = we_seen_q;
endmodule

// File: rtl/bsram_lane_mem.sv
module bsram_lane_mem
  import bsram_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [LANE_W-1:0] wdata_i,
  output logic [LANE_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] mem_q [DEPTH];
  logic [LANE_W-1:0] rd_q;

  always_ff @(posedge clk_i) begin
    if (wr_i) mem_q[addr_i] <= wdata_i;
    rd_q <= mem_q[addr_i];
  end

  assign rdata_o = rd_q;
endmodule

// File: rtl/bsram_lane_ctrl.sv
module bsram_lane_ctrl
  import bsram_pkg::*;
#(
  parameter int unsigned ADDR_W       = 6,
  parameter bit          PARAM_LINEAR = 1'b0
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic                  cs_ni,
  input  logic                  cpu_stb_ni,
  input  logic                  ctl_stb_ni,
  input  logic                  adv_ni,
  input  logic [1:0]            lane_we_ni,
  input  logic                  oe_ni,
  input  logic [17:0]           wdata_i,
  output logic [17:0]           rdata_o,
  output logic [1:0]            lane_oe_o
);
  logic              load, step, sel;
  logic [LANES-1:0]  lane_wr, we_seen;
  logic [ADDR_W-1:0] eff_addr;

  bsram_cycle_ctrl i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_ni      (cs_ni),
    .cpu_stb_ni (cpu_stb_ni),
    .ctl_stb_ni (ctl_stb_ni),
    .adv_ni     (adv_ni),
    .lane_we_ni (lane_we_ni),
    .load_o     (load),
    .step_o     (step),
    .lane_wr_o  (lane_wr),
    .sel_o      (sel),
    .we_seen_o  (we_seen)
  );

  bsram_addr_gen #(
    .ADDR_W       (ADDR_W),
    .PARAM_LINEAR (PARAM_LINEAR)
  ) i_agen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .step_i     (step),
    .addr_i     (addr_i),
    .eff_addr_o (eff_addr)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] rd;

    bsram_lane_mem #(.ADDR_W(ADDR_W)) i_mem (
      .clk_i   (clk_i),
      .addr_i  (eff_addr),
      .wr_i    (lane_wr[l]),
      .wdata_i (wdata_i[l*LANE_W +: LANE_W]),
      .rdata_o (rd)
    );

    // output enable is asynchronous; the sampled write enable forces the lane off
    assign lane_oe_o[l] = sel && !we_seen[l] && !oe_ni;
    assign rdata_o[l*LANE_W +: LANE_W] = lane_oe_o[l] ? rd : '0;
  end
endmodule

// File: rtl/bsram_lane_ctrl_chk.sv
module bsram_lane_ctrl_chk #(
  parameter int unsigned ADDR_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_ni,
  input logic              ctl_stb_ni,
  input logic [1:0]        lane_we_ni,
  input logic              oe_ni,
  input logic [17:0]       rdata_o,
  input logic [1:0]        lane_oe_o,
  input logic [ADDR_W-1:0] addr_i
);
  p_oe_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> (lane_oe_o == 2'b00));

  p_lane0_we_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lane_we_ni[0] |=> !lane_oe_o[0]);

  p_lane1_we_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lane_we_ni[1] |=> !lane_oe_o[1]);

  p_desel_off_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && !ctl_stb_ni) |=> (lane_oe_o == 2'b00));

  p_lane0_idle_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lane_oe_o[0] |-> (rdata_o[8:0] == 9'd0));

  p_lane1_idle_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lane_oe_o[1] |-> (rdata_o[17:9] == 9'd0));

  logic unused_addr;
  assign unused_addr = ^addr_i;
endmodule

bind bsram_lane_ctrl bsram_lane_ctrl_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_ni      (cs_ni),
  .ctl_stb_ni (ctl_stb_ni),
  .lane_we_ni (lane_we_ni),
  .oe_ni      (oe_ni),
  .rdata_o    (rdata_o),
  .lane_oe_o  (lane_oe_o),
  .addr_i     (addr_i)
);

// File: tb/test_bsram_lane_ctrl.sv
`timescale 1ns/1ps
module test_bsram_lane_ctrl;
  localparam int AW = 6;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          cs_ni = 1'b1, cpu_stb_ni = 1'b1, ctl_stb_ni = 1'b1, adv_ni = 1'b1;
  logic [1:0]    lane_we_ni = 2'b11;
  logic          oe_ni = 1'b1;
  logic [17:0]   wdata_i = '0;
  logic [17:0]   rdata_o;
  logic [1:0]    lane_oe_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  bsram_lane_ctrl #(.ADDR_W(AW), .PARAM_LINEAR(1'b0)) i_bsram_lane_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .cs_ni(cs_ni),
    .cpu_stb_ni(cpu_stb_ni), .ctl_stb_ni(ctl_stb_ni), .adv_ni(adv_ni),
    .lane_we_ni(lane_we_ni), .oe_ni(oe_ni), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .lane_oe_o(lane_oe_o)
  );

  always #5 clk_i = ~clk_i;

  // reference state, built from the requirements
  logic [8:0]    m_mem [2][64];
  logic [AW-3:0] m_base = '0;
  logic [1:0]    m_start = '0, m_k = '0;
  logic          m_sel = 1'b0;

  logic [19:0] q_v [$];
  string       q_t [$];

  task automatic check(input string tag, input logic [19:0] act, input logic [19:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual oe=%b data=%h expected oe=%b data=%h",
               tag, act[19:18], act[17:0], exp[19:18], exp[17:0]);
    end
  endtask

  task automatic cyc(input string tag, input logic cs, input logic cpu, input logic ctl,
                     input logic adv, input logic [1:0] we, input logic oe,
                     input logic [AW-1:0] a, input logic [17:0] wd);
    logic cpu_l, ctl_l, dsel;
    logic [AW-1:0] eff;
    logic [8:0] rd [2];
    logic [1:0] eo;
    logic [17:0] ed;
    @(negedge clk_i);
    cs_ni = cs; cpu_stb_ni = cpu; ctl_stb_ni = ctl; adv_ni = adv;
    lane_we_ni = we; oe_ni = oe; addr_i = a; wdata_i = wd;
    cpu_l = !cs && !cpu;
    ctl_l = !cs && !ctl && cpu;
    dsel  = cs && !ctl;
    if (cpu_l || ctl_l) begin
      m_base = a[AW-1:2]; m_start = a[1:0]; m_k = 2'd0;
    end else if (!dsel && !adv) begin
      m_k = m_k + 2'd1;
    end
    eff = {m_base, m_start ^ m_k}; // R6 interleaved order
    for (int l = 0; l < 2; l++) begin
      rd[l] = m_mem[l][eff];
      if (!we[l] && !cpu_l && !dsel) m_mem[l][eff] = wd[l*9 +: 9];
    end
    if (cpu_l || ctl_l) m_sel = 1'b1;
    else if (dsel)      m_sel = 1'b0;
    for (int l = 0; l < 2; l++) eo[l] = m_sel && we[l] && !oe;
    ed = {eo[1] ? rd[1] : 9'd0, eo[0] ? rd[0] : 9'd0};
    q_v.push_back({eo, ed});
    q_t.push_back(tag);
  endtask

  // monitor: sample between edges, after the outputs settle
  initial begin
    forever begin
      @(posedge clk_i);
      #2;
      if (q_v.size() > 0) check(q_t.pop_front(), {lane_oe_o, rdata_o}, q_v.pop_front());
    end
  end

  task automatic idle(input string tag, input logic oe);
    cyc(tag, 1'b1, 1'b1, 1'b1, 1'b1, 2'b11, oe, '0, '0);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 reset", {lane_oe_o, rdata_o}, 20'd0);

    // R4 controller write, then R8 read back; R2 lane layout
    cyc("R4 wr", 0, 1, 0, 1, 2'b00, 1, 6'h10, 18'h2A5A5);
    cyc("R8 rd", 0, 1, 0, 1, 2'b11, 0, 6'h10, '0);
    idle("R8 data", 0);
    // R2 partial write of lane 0 only; lane 1 keeps old value
    cyc("R2 lo", 0, 1, 0, 1, 2'b10, 0, 6'h10, 18'h3FF33);
    cyc("R2 rd", 0, 1, 0, 1, 2'b11, 0, 6'h10, '0);
    idle("R2 data", 0);
    // same-cycle read of lane 1 while lane 0 written (R10)
    cyc("R10 split", 0, 1, 0, 1, 2'b10, 0, 6'h10, 18'h00111);
    idle("R10 split rd", 0);

    // R3 processor strobe: write enables ignored
    cyc("R3 pre", 0, 1, 0, 1, 2'b00, 1, 6'h20, 18'h12345);
    cyc("R3 ign", 0, 0, 1, 1, 2'b00, 0, 6'h20, 18'h0BEEF);
    cyc("R3 hold", 1, 1, 1, 1, 2'b11, 0, 6'h00, '0);
    cyc("R3 rd", 0, 1, 0, 1, 2'b11, 0, 6'h20, '0);
    idle("R3 data", 0);
    // R3 write at the following edge
    cyc("R3 addr", 0, 0, 1, 1, 2'b11, 1, 6'h20, '0);
    cyc("R3 wr2", 1, 1, 1, 1, 2'b00, 1, 6'h00, 18'h2F0F0);
    cyc("R3 rd2", 0, 1, 0, 1, 2'b11, 0, 6'h20, '0);
    idle("R3 data2", 0);

    // R5/R6 burst write from 0x32 with cs high, R7 adv ignored on load
    cyc("R7 load", 0, 1, 0, 0, 2'b00, 1, 6'h32, 18'h00A01);
    cyc("R5 b1", 1, 1, 1, 0, 2'b00, 1, 6'h00, 18'h00B02);
    cyc("R5 b2", 1, 1, 1, 0, 2'b00, 1, 6'h00, 18'h00C03);
    cyc("R5 b3", 1, 1, 1, 0, 2'b01, 1, 6'h00, 18'h15D04);
    // R6 burst read via processor strobe, interleaved order
    cyc("R6 ld", 0, 0, 1, 1, 2'b11, 0, 6'h32, '0);
    cyc("R6 s1", 1, 1, 1, 0, 2'b11, 0, 6'h00, '0);
    cyc("R7 hold", 1, 1, 1, 1, 2'b11, 0, 6'h00, '0);
    cyc("R6 s2", 1, 1, 1, 0, 2'b11, 0, 6'h00, '0);
    cyc("R6 s3", 1, 1, 1, 0, 2'b11, 0, 6'h00, '0);
    cyc("R6 wrap", 1, 1, 1, 0, 2'b11, 0, 6'h00, '0);
    // R11 processor strobe with cs high acts as burst step
    cyc("R11 cpu ign", 1, 0, 1, 0, 2'b11, 0, 6'h10, '0);
    // R9 oe high
    idle("R9 oe", 1);
    // R10 write enable low on processor-strobe edge turns lane off
    cyc("R10 cpu", 0, 0, 1, 1, 2'b01, 0, 6'h10, '0);
    idle("R10 after", 0);
    // R11 deselect
    cyc("R11 desel", 1, 1, 0, 1, 2'b11, 0, 6'h10, '0);
    cyc("R11 stay", 1, 1, 1, 0, 2'b11, 0, 6'h00, '0);
    cyc("R11 nowr", 1, 1, 0, 1, 2'b00, 0, 6'h10, 18'h3FFFF);
    cyc("R11 rd", 0, 1, 0, 1, 2'b11, 0, 6'h10, '0);
    idle("R11 data", 0);
    // R12 both strobes low, cs low: processor wins, no write
    cyc("R12 both", 0, 0, 0, 1, 2'b00, 0, 6'h20, 18'h11111);
    cyc("R12 rd", 0, 1, 0, 1, 2'b11, 0, 6'h20, '0);
    idle("R12 data", 0);
    idle("R9 end", 1);

    repeat (3) @(negedge clk_i);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule